// File: doc/BRIEF.md
# Dynamic Write Termination Selector

This block belongs to the behavioural model of a DDR3-style memory device. On every clock it picks which on-die termination setting the data pins present: high-impedance, the nominal value, or a separate write value. Without this block, switching between the nominal and write values would take a mode-register update. The block makes the switch on its own for the length of each write burst and returns to the nominal setting when the burst is over.

A decoded WRITE command, qualified by a burst-length flag, enters a delay line that is `CHG_LAT` clocks long. When the command leaves the delay line, a hold counter loads a value that depends on the burst length. The write code is driven while that counter is non-zero. A WRITE that arrives before the counter runs out reloads it, so the write code stays on without a gap across back-to-back writes. A write-leveling flag blocks the swap. When no write is in progress, the output follows the ODT pin and the nominal termination field.

Top module: `dyn_term_sel`

## Requirements
- R1: `rst` is a synchronous active-high reset. Every clock edge that samples it high sets `term_code` to 00 and discards any WRITE still in the delay line or the hold counter.
- R2: `term_code` uses three codes: 00 high-impedance, 01 nominal, 10 write. The code 11 is never driven.
- R3: When no write hold is active, a clock edge that samples `odt_req` high and `nom_sel` non-zero gives `term_code` 01 in the following cycle. Any other combination gives 00.
- R4: The write-termination enable field `wr_sel[1:0]` is sampled together with `wr_cmd`. A value of 00 makes that WRITE have no effect on `term_code`. Any non-zero value allows the swap.
- R5: When an enabled WRITE is sampled at edge k, `term_code` becomes 10 at edge k+`CHG_LAT` (default 4) and not sooner.
- R6: The write code is held for `HOLD_BL4` cycles (default 4) when `wr_bl8`=0 and for `HOLD_BL8` cycles (default 6) when `wr_bl8`=1. After that the output returns to the R3 value.
- R7: An enabled WRITE whose delay ends while a hold is still running reloads the hold counter with that WRITE's own hold value. The write code then stays on without a break.
- R8: A WRITE sampled while `wlvl_mode` is high is ignored. An edge that samples `wlvl_mode` high never produces `term_code` 10 in the following cycle.
- R9: The write code does not depend on `odt_req` or `nom_sel`. With the nominal setting disabled, a write burst gives 10 and the output then falls back to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| odt_req | input | 1 | Termination request pin level |
| wr_cmd | input | 1 | Decoded WRITE command strobe, one cycle |
| wr_bl8 | input | 1 | Burst length of this WRITE: 1 = 8 beats, 0 = 4 beats |
| wlvl_mode | input | 1 | Write-leveling mode active |
| nom_sel | input | 3 | Nominal termination field, non-zero = enabled |
| wr_sel | input | 2 | Write termination field, non-zero = enabled |
| term_code | output | 2 | Selected termination: 00 high-Z, 01 nominal, 10 write |

## Verification
`term_code` is a register. Idle-path changes and the effects of reset and write-leveling therefore show one cycle after the edge that samples the stimulus. A WRITE sampled at edge k shows the write code from edge k+4 through edge k+4+hold-1. The bench drives inputs on falling edges. After each command it counts falling edges, so the sample taken at falling edge m reflects edge k+m. For every m it compares against a value worked out from the latency and hold rules. The checks cover the cycle just before the swap and the cycle just after the restore, which catch off-by-one errors in the latency and the hold.

// File: rtl/dyn_term_sel.sv
module dyn_term_sel #(
  parameter int CHG_LAT  = 4,
  parameter int HOLD_BL4 = 4,
  parameter int HOLD_BL8 = 6,
  localparam int HMAX = (HOLD_BL8 > HOLD_BL4) ? HOLD_BL8 : HOLD_BL4,
  localparam int CW   = $clog2(HMAX + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       odt_req,
  input  logic       wr_cmd,
  input  logic       wr_bl8,
  input  logic       wlvl_mode,
  input  logic [2:0] nom_sel,
  input  logic [1:0] wr_sel,
  output logic [1:0] term_code
);

  localparam logic [1:0] CODE_HIZ = 2'b00;
  localparam logic [1:0] CODE_NOM = 2'b01;
  localparam logic [1:0] CODE_WR  = 2'b10;

  logic [CHG_LAT-1:0] pipe_v;
  logic [CHG_LAT-1:0] pipe_b;
  logic [CW-1:0]      hold_cnt;
  logic [CW-1:0]      hold_nx;
  logic [CW-1:0]      hold_load;
  logic [1:0]         idle_code;
  logic [1:0]         code_nx;
  logic               capture;
  logic               start;

  assign capture   = wr_cmd && (wr_sel != 2'b00) && !wlvl_mode;
  assign start     = pipe_v[CHG_LAT-1];
  assign hold_load = pipe_b[CHG_LAT-1] ? CW'(HOLD_BL8) : CW'(HOLD_BL4);
  assign hold_nx   = start ? hold_load :
                     (hold_cnt != '0) ? hold_cnt - 1'b1 : '0;
  assign idle_code = (odt_req && nom_sel != 3'b000) ? CODE_NOM : CODE_HIZ;
  assign code_nx   = (hold_nx != '0 && !wlvl_mode) ? CODE_WR : idle_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_v    <= '0;
      pipe_b    <= '0;
      hold_cnt  <= '0;
      term_code <= CODE_HIZ;
    end else begin
      for (int i = 0; i < CHG_LAT; i++) begin
        if (i == 0) begin
          pipe_v[i] <= capture;
          pipe_b[i] <= wr_bl8;
        end else begin
          pipe_v[i] <= pipe_v[i-1];
          pipe_b[i] <= pipe_b[i-1];
        end
      end
      hold_cnt  <= hold_nx;
      term_code <= code_nx;
    end
  end

endmodule

// File: rtl/dyn_term_sel_chk.sv
module dyn_term_sel_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          odt_req,
  input logic          wlvl_mode,
  input logic [2:0]    nom_sel,
  input logic          start,
  input logic [CW-1:0] hold_cnt,
  input logic [1:0]    term_code
);

  AST_RESET_HIZ: assert property (@(posedge clk) rst |=> term_code == 2'b00); // R1

  AST_NO_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
    term_code != 2'b11); // R2

  AST_IDLE_NOM: assert property (@(posedge clk) disable iff (rst)
    (hold_cnt <= 1 && !start && odt_req && nom_sel != 3'b000) |=> term_code == 2'b01); // R3

  AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (rst)
    (hold_cnt <= 1 && !start && !(odt_req && nom_sel != 3'b000)) |=> term_code == 2'b00); // R3

  AST_SWAP_ON_START: assert property (@(posedge clk) disable iff (rst)
    (start && !wlvl_mode) |=> term_code == 2'b10); // R5

  AST_WLVL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    wlvl_mode |=> term_code != 2'b10); // R8

endmodule

bind dyn_term_sel dyn_term_sel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .odt_req(odt_req), .wlvl_mode(wlvl_mode),
  .nom_sel(nom_sel), .start(start), .hold_cnt(hold_cnt), .term_code(term_code)
);

// File: tb/dyn_term_sel_tb.sv
module dyn_term_sel_tb;
  localparam int LAT = 4;
  localparam int H4  = 4;
  localparam int H8  = 6;

  logic       clk = 0;
  logic       rst = 1;
  logic       odt_req = 0, wr_cmd = 0, wr_bl8 = 0, wlvl_mode = 0;
  logic [2:0] nom_sel = 0;
  logic [1:0] wr_sel = 0;
  logic [1:0] term_code;
  int checks = 0, errors = 0;

  dyn_term_sel u_dut (.clk(clk), .rst(rst), .odt_req(odt_req), .wr_cmd(wr_cmd),
    .wr_bl8(wr_bl8), .wlvl_mode(wlvl_mode), .nom_sel(nom_sel), .wr_sel(wr_sel),
    .term_code(term_code));

  always #10 clk = ~clk;

  task automatic chk(input logic [1:0] exp, input string req, input int m);
    checks++;
    if (term_code !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: term_code=%b expected=%b", req, m, term_code, exp);
    end
  endtask

  function automatic logic [1:0] idle_val();
    return (odt_req && nom_sel != 0) ? 2'b01 : 2'b00;
  endfunction

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_burst(input logic bl8, input logic [1:0] sel, input string req);
    int h = bl8 ? H8 : H4;
    logic [1:0] idl = idle_val();
    wr_bl8 = bl8; wr_sel = sel; wr_cmd = 1;
    for (int m = 0; m <= LAT + h + 1; m++) begin
      @(negedge clk);
      if (m == 0) wr_cmd = 0;
      if (sel != 0 && m >= LAT && m < LAT + h) chk(2'b10, req, m);
      else chk(idl, req, m);
    end
  endtask

  task automatic t_reset();
    rst = 1; settle(2);
    chk(2'b00, "R1", 0);
    rst = 0; settle(1);
    chk(2'b00, "R2", 0);
  endtask

  task automatic t_idle();
    odt_req = 1; nom_sel = 3'd2; settle(1); chk(2'b01, "R3", 0);
    nom_sel = 0; settle(1); chk(2'b00, "R3", 1);
    odt_req = 0; nom_sel = 3'd5; settle(1); chk(2'b00, "R3", 2);
    odt_req = 1; settle(1); chk(2'b01, "R3", 3);
  endtask

  task automatic t_bl4(); write_burst(1'b0, 2'b01, "R5 R6 bl4"); endtask
  task automatic t_bl8(); write_burst(1'b1, 2'b10, "R6 bl8"); endtask
  task automatic t_disabled(); write_burst(1'b1, 2'b00, "R4"); endtask

  task automatic t_nom_off();
    nom_sel = 0; odt_req = 1; settle(1);
    write_burst(1'b0, 2'b11, "R9");
    odt_req = 0; settle(1);
    write_burst(1'b1, 2'b01, "R9 pin low");
    odt_req = 1; nom_sel = 3'd1; settle(1);
  endtask

  task automatic t_back_to_back();
    wr_bl8 = 0; wr_sel = 2'b01; wr_cmd = 1;
    for (int m = 0; m <= 13; m++) begin
      @(negedge clk);
      wr_cmd = (m == 2);
      if (m >= LAT && m <= 3 + LAT + H4 - 1) chk(2'b10, "R7", m);
      else chk(2'b01, "R7", m);
    end
  endtask

  task automatic t_wlvl();
    wlvl_mode = 1; wr_bl8 = 1; wr_sel = 2'b01; wr_cmd = 1;
    for (int m = 0; m <= 12; m++) begin
      @(negedge clk);
      if (m == 0) wr_cmd = 0;
      if (m == 0) wlvl_mode = 0;
      chk(2'b01, "R8 ignored", m);
    end
    wr_cmd = 1;
    for (int m = 0; m <= 12; m++) begin
      @(negedge clk);
      if (m == 0) wr_cmd = 0;
      if (m == 5) wlvl_mode = 1;
      if (m == 7) wlvl_mode = 0;
      if (m == 4 || m == 5) chk(2'b10, "R8 before", m);
      if (m == 6 || m == 7) chk(2'b01, "R8 masked", m);
    end
  endtask

  task automatic t_reset_mid();
    wr_bl8 = 1; wr_sel = 2'b01; wr_cmd = 1;
    for (int m = 0; m <= 12; m++) begin
      @(negedge clk);
      if (m == 0) wr_cmd = 0;
      if (m == 1) rst = 1;
      if (m == 2) begin chk(2'b00, "R1 reset", m); rst = 0; end
      if (m >= 3) chk(2'b01, "R1 discarded", m);
    end
  endtask

  initial begin
    settle(200000);
    errors++;
    $display("FAIL watchdog: expected=finish actual=timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_bl4();
    t_bl8();
    t_disabled();
    t_nom_off();
    t_back_to_back();
    t_wlvl();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule